// File: doc/BRIEF.md
# Bit-Alias Access Converter

This block sits between a processor-side memory port and the memory or peripheral bus. It turns single-bit accesses into word accesses. Two alias windows are decoded, one over the data region and one over the peripheral region. Each word-aligned address in a window stands for exactly one bit of the region below it. The converter works out the containing word and the bit position, and then runs the word-level bus traffic that the processor would otherwise have to code by hand.

A read of an alias address becomes one word read. The selected bit comes back in bit 0 and every other bit is zero. The response arrives in the same cycle as a normal load, because the mask and the shift are combinational on the returning data. A write of an alias address is accepted from the processor in one cycle. It then becomes a word read followed, in the very next cycle, by a word write to the same address. The write carries the old word with only the addressed bit replaced. The processor side is held off for that one write-back cycle. Any address outside both windows is forwarded untouched.

The memory side is assumed to accept every request at once and to return read data in the cycle after the request.

Top module: `bb_alias_bridge`

## Requirements
- R1: An address in 0x22000000–0x23FFFFFF maps to word 0x20000000 + ((addr[24:0] >> 7) << 2). The bit within that word is addr[6:2]. Address bits [1:0] are ignored.
- R2: An address in 0x42000000–0x43FFFFFF maps in the same way, onto the words above 0x40000000.
- R3: An alias read issues exactly one word read to the mapped word. In the cycle after acceptance, cpu_rvalid is high and cpu_rdata holds the selected bit in bit 0, with bits [31:1] zero.
- R4: An alias write issues a read of the mapped word and, in the next cycle, a write to the same word. The written data equals the word just read, except that the selected bit takes the value of cpu_wdata[0]. Bits [31:1] of cpu_wdata have no effect.
- R5: An alias write is accepted in one cycle. cpu_ready is then low for exactly the one write-back cycle, so a following access waits exactly one cycle. Every other access completes with no stall.
- R6: A non-alias access is forwarded in its own cycle with the same address, direction, size and write data. Its read data is returned unchanged one cycle later.
- R7: While reset is high and after it is released, the block is idle: cpu_ready is high, cpu_rvalid is low and no memory request is made without a processor request.
- R8: Every memory transfer generated from an alias access uses word size (mem_size = 2; the encoding is 0 for byte, 1 for halfword, 2 for word).
- R9: Addresses just outside the windows, such as 0x21FFFFFC, 0x24000000 and 0x44000000, are passed through as non-alias accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ready | output | 1 | Request accepted this cycle when high |
| cpu_rvalid | output | 1 | Read response valid |
| cpu_rdata | output | 32 | Read response data |
| mem_req | output | 1 | Memory-side transfer request |
| mem_we | output | 1 | Memory-side write |
| mem_addr | output | 32 | Memory-side address |
| mem_size | output | 2 | Memory-side size |
| mem_wdata | output | 32 | Memory-side write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the request |

## Verification
The bench aims at the window edges: the first and last alias words of each window, and the addresses just beside them. A wrong bit-field slice would land on a neighbouring word or bit, and a loose window compare would convert an ordinary access. It sets and clears bits with write data whose upper bits oppose bit 0. A design that used the wrong bit of the write data, or that disturbed other bits of the word, would show a mismatched write-back word. It also issues an access right behind an alias write, and an alias read of the bit just written. A design with no stall, or with two stall cycles, would show the wrong wait count or the wrong bus order. A late write-back would return the old bit.

// File: rtl/bb_alias_pkg.sv
package bb_alias_pkg;

    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int BIT_W    = $clog2(DATA_W);
    localparam int NUM_WIN  = 2;
    // Each alias window spans 2**OFF_W bytes.
    localparam int OFF_W    = 25;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [BIT_W-1:0]  bitidx_t;

    // Window 0 covers the data region, window 1 covers the peripheral region.
    localparam logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000};
    localparam logic [NUM_WIN-1:0][ADDR_W-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000};

    typedef struct packed {
        logic    hit;
        addr_t   word_addr;
        bitidx_t bit_idx;
    } alias_map_t;

    typedef struct packed {
        logic       req;
        logic       we;
        addr_t      addr;
        logic [1:0] size;
        data_t      wdata;
    } xfer_t;

    typedef enum logic {ST_IDLE, ST_WBACK} state_e;

    function automatic data_t bit_extract(data_t word, bitidx_t idx);
        data_t r;
        r    = '0;
        r[0] = word[idx];
        return r;
    endfunction

    function automatic data_t bit_merge(data_t word, bitidx_t idx, logic val);
        data_t r;
        r      = word;
        r[idx] = val;
        return r;
    endfunction

endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode
    import bb_alias_pkg::*;
(
    input  logic [ADDR_W-3:0] word_in,
    output alias_map_t        map_o
);

    localparam int SEL_LSB = OFF_W - 2;
    localparam int WSEL_W  = OFF_W - 2 - BIT_W;
    localparam int PAD_W   = ADDR_W - WSEL_W - 2;

    logic  [NUM_WIN-1:0]             win_hit;
    logic  [NUM_WIN-1:0][ADDR_W-1:0] cand_addr;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign win_hit[g]   = (word_in[ADDR_W-3:SEL_LSB] == ALIAS_BASE[g][ADDR_W-1:OFF_W]);
        assign cand_addr[g] = REGION_BASE[g]
                            + {{PAD_W{1'b0}}, word_in[SEL_LSB-1:BIT_W], 2'b00};
    end

    always_comb begin
        map_o = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_hit[i]) begin
                map_o.hit       = 1'b1;
                map_o.word_addr = cand_addr[i];
            end
        end
        map_o.bit_idx = word_in[BIT_W-1:0];
    end

endmodule

// File: rtl/bb_alias_seq.sv
module bb_alias_seq
    import bb_alias_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic       we,
    input  alias_map_t map_i,
    input  logic       wbit,
    output logic       wb_active,
    output addr_t      wb_addr,
    output bitidx_t    wb_bit,
    output logic       wb_val,
    output logic       rd_pend,
    output logic       rd_alias,
    output bitidx_t    rd_bit
);

    state_e state;

    assign wb_active = (state == ST_WBACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            rd_pend <= 1'b0;
        end else begin
            rd_pend <= accept && !we;
            case (state)
                ST_IDLE:  if (accept && we && map_i.hit) state <= ST_WBACK;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            rd_alias <= map_i.hit;
            rd_bit   <= map_i.bit_idx;
            wb_addr  <= map_i.word_addr;
            wb_bit   <= map_i.bit_idx;
            wb_val   <= wbit;
        end
    end

endmodule

// File: rtl/bb_alias_bridge.sv
module bb_alias_bridge
    import bb_alias_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    alias_map_t map;
    logic       accept;
    logic       wb_active;
    addr_t      wb_addr;
    bitidx_t    wb_bit;
    logic       wb_val;
    logic       rd_pend;
    logic       rd_alias;
    bitidx_t    rd_bit;
    xfer_t      xo;

    bb_alias_decode u_decode (
        .word_in (cpu_addr[ADDR_W-1:2]),
        .map_o   (map)
    );

    assign cpu_ready = !wb_active;
    assign accept    = cpu_req && cpu_ready;

    bb_alias_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .we        (cpu_we),
        .map_i     (map),
        .wbit      (cpu_wdata[0]),
        .wb_active (wb_active),
        .wb_addr   (wb_addr),
        .wb_bit    (wb_bit),
        .wb_val    (wb_val),
        .rd_pend   (rd_pend),
        .rd_alias  (rd_alias),
        .rd_bit    (rd_bit)
    );

    always_comb begin
        xo = '0;
        if (wb_active) begin
            xo.req   = 1'b1;
            xo.we    = 1'b1;
            xo.addr  = wb_addr;
            xo.size  = SIZE_WORD;
            xo.wdata = bit_merge(mem_rdata, wb_bit, wb_val);
        end else if (cpu_req) begin
            xo.req = 1'b1;
            if (map.hit) begin
                xo.we   = 1'b0;
                xo.addr = map.word_addr;
                xo.size = SIZE_WORD;
            end else begin
                xo.we    = cpu_we;
                xo.addr  = cpu_addr;
                xo.size  = cpu_size;
                xo.wdata = cpu_wdata;
            end
        end
    end

    assign mem_req    = xo.req;
    assign mem_we     = xo.we;
    assign mem_addr   = xo.addr;
    assign mem_size   = xo.size;
    assign mem_wdata  = xo.wdata;

    assign cpu_rvalid = rd_pend;
    assign cpu_rdata  = rd_alias ? bit_extract(mem_rdata, rd_bit) : mem_rdata;

endmodule

// File: rtl/bb_alias_bridge_chk.sv
module bb_alias_bridge_chk
    import bb_alias_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [1:0]        cpu_size,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_ready,
    input logic              cpu_rvalid,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_size,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] mem_rdata
);

    logic in_win;
    logic acc;

    always_comb begin
        in_win = 1'b0;
        for (int i = 0; i < NUM_WIN; i++)
            if (cpu_addr[ADDR_W-1:OFF_W] == ALIAS_BASE[i][ADDR_W-1:OFF_W]) in_win = 1'b1;
    end

    assign acc = cpu_req && cpu_ready;

    assert_reset_idle_R7: assert property (@(posedge clk)
        rst |=> cpu_ready && !cpu_rvalid);

    assert_rd_bit0_R3: assert property (@(posedge clk) disable iff (rst)
        acc && !cpu_we && in_win |=> cpu_rvalid && (cpu_rdata[DATA_W-1:1] == '0));

    assert_wb_follows_R4: assert property (@(posedge clk) disable iff (rst)
        acc && cpu_we && in_win |=> mem_req && mem_we && (mem_addr == $past(mem_addr)));

    assert_wb_one_bit_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req && !cpu_ready |-> mem_we && ($countones(mem_wdata ^ mem_rdata) <= 1));

    assert_stall_R5: assert property (@(posedge clk) disable iff (rst)
        acc && cpu_we && in_win |=> !cpu_ready);

    assert_stall_once_R5: assert property (@(posedge clk) disable iff (rst)
        !cpu_ready |=> cpu_ready);

    assert_pass_R6: assert property (@(posedge clk) disable iff (rst)
        acc && !in_win |-> mem_req && mem_we == cpu_we && mem_addr == cpu_addr
                           && mem_size == cpu_size && mem_wdata == cpu_wdata);

    assert_word_size_R8: assert property (@(posedge clk) disable iff (rst)
        acc && in_win |-> mem_req && !mem_we && mem_size == SIZE_WORD);

endmodule

bind bb_alias_bridge bb_alias_bridge_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_size   (cpu_size),
    .cpu_wdata  (cpu_wdata),
    .cpu_ready  (cpu_ready),
    .cpu_rvalid (cpu_rvalid),
    .cpu_rdata  (cpu_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata)
);

// File: tb/bb_alias_bridge_test.sv
module bb_alias_bridge_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic        cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    always #4 clk = ~clk;

    bb_alias_bridge uut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic int midx(logic [31:0] a);
        return int'({a[30], a[10:2]});
    endfunction

    function automatic logic [31:0] seed(int i);
        return (i * 32'h9E37_79B1) ^ 32'h5A3C_C3A5;
    endfunction

    // Memory model: accepts every request, read data one cycle later.
    logic [31:0] mem_model [0:1023];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) mem_model[i] <= seed(i);
        end else if (mem_req) begin
            if (mem_we) mem_model[midx(mem_addr)] <= mem_wdata;
            else        mem_rdata <= mem_model[midx(mem_addr)];
        end
    end

    logic [31:0] shadow [0:1023];
    initial for (int i = 0; i < 1024; i++) shadow[i] = seed(i);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic [31:0] cyc;
    } mexp_t;
    typedef struct packed {
        logic [31:0] data;
        logic [31:0] cyc;
    } rexp_t;

    mexp_t mq[$];
    string mtag[$];
    rexp_t rq[$];
    string rtag[$];

    int vectors = 0;
    int fails = 0;
    logic prev_aw = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: computes expectations from the requirements, then drives.
    task automatic acc(input logic we, input logic [31:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input string tag);
        logic        hit;
        logic [31:0] tgt;
        logic [31:0] nw;
        int          b;
        int          waited;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
        #1;
        waited = 0;
        while (!cpu_ready) begin
            @(negedge clk); #1;
            waited++;
        end
        chk("R5", waited, prev_aw ? 32'd1 : 32'd0, "stall cycles");
        hit = (a[31:25] == 7'h11) || (a[31:25] == 7'h21);
        if (hit) begin
            tgt = {a[31:28], 28'h0} + ((a & 32'h01FF_FFFF) >> 7 << 2);
            b   = int'(a[6:2]);
            mq.push_back('{1'b0, tgt, 2'd2, 32'd0, 32'(cyc)});
            mtag.push_back({tag, " R8"});
            if (!we) begin
                rq.push_back('{{31'd0, shadow[midx(tgt)][b]}, 32'(cyc + 1)});
                rtag.push_back({tag, " R3"});
            end else begin
                nw = shadow[midx(tgt)];
                nw[b] = wd[0];
                mq.push_back('{1'b1, tgt, 2'd2, nw, 32'(cyc + 1)});
                mtag.push_back({tag, " R4"});
                shadow[midx(tgt)] = nw;
            end
            prev_aw = we;
        end else begin
            mq.push_back('{we, a, sz, wd, 32'(cyc)});
            mtag.push_back({tag, " R6"});
            if (!we) begin
                rq.push_back('{shadow[midx(a)], 32'(cyc + 1)});
                rtag.push_back({tag, " R6"});
            end else begin
                shadow[midx(a)] = wd;
            end
            prev_aw = 1'b0;
        end
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic idle(input int n);
        cpu_req = 1'b0;
        prev_aw = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expectations as the design produces bus and read traffic.
    initial begin
        mexp_t m;
        rexp_t r;
        string t;
        forever begin
            @(negedge clk); #2;
            if (!rst) begin
                if (mem_req) begin
                    if (mq.size() == 0) begin
                        chk("R5", 32'd1, 32'd0, "unexpected memory transfer");
                    end else begin
                        m = mq.pop_front();
                        t = mtag.pop_front();
                        chk(t, 32'(cyc), m.cyc, "transfer cycle");
                        chk(t, {31'd0, mem_we}, {31'd0, m.we}, "mem_we");
                        chk(t, mem_addr, m.addr, "mem_addr");
                        chk(t, {30'd0, mem_size}, {30'd0, m.size}, "mem_size");
                        if (m.we) chk(t, mem_wdata, m.wdata, "mem_wdata");
                    end
                end
                if (cpu_rvalid) begin
                    if (rq.size() == 0) begin
                        chk("R3", 32'd1, 32'd0, "unexpected read response");
                    end else begin
                        r = rq.pop_front();
                        t = rtag.pop_front();
                        chk(t, 32'(cyc), r.cyc, "response cycle");
                        chk(t, cpu_rdata, r.data, "cpu_rdata");
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R7", {31'd0, cpu_ready}, 32'd1, "ready in reset");
        chk("R7", {31'd0, mem_req}, 32'd0, "mem_req in reset");
        chk("R7", {31'd0, cpu_rvalid}, 32'd0, "rvalid in reset");
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R7", {31'd0, cpu_ready}, 32'd1, "ready after reset");
        chk("R7", {31'd0, mem_req}, 32'd0, "mem_req after reset");
        @(negedge clk);

        // Plain word access in the data region
        acc(1'b1, 32'h2000_0010, 2'd2, 32'hA5A5_0F0F, "R6");
        acc(1'b0, 32'h2000_0010, 2'd2, 32'h0, "R6");
        // Alias reads of several bits of that word
        acc(1'b0, 32'h2200_0200, 2'd2, 32'h0, "R1");
        acc(1'b0, 32'h2200_0204, 2'd2, 32'h0, "R1");
        acc(1'b0, 32'h2200_027C, 2'd2, 32'h0, "R1");
        acc(1'b0, 32'h2200_0236, 2'd2, 32'h0, "R1");
        // Clear bit 4 with upper write-data bits set, then read it back-to-back
        acc(1'b1, 32'h2200_0210, 2'd2, 32'hFFFF_FFFE, "R4");
        acc(1'b0, 32'h2200_0210, 2'd2, 32'h0, "R5");
        acc(1'b0, 32'h2000_0010, 2'd2, 32'h0, "R4");
        // Set bit 6 with upper bits clear, idle through the write-back
        acc(1'b1, 32'h2200_0218, 2'd2, 32'h0000_0001, "R4");
        idle(2);
        acc(1'b0, 32'h2000_0010, 2'd2, 32'h0, "R4");
        // Peripheral window
        acc(1'b1, 32'h4200_2024, 2'd2, 32'h0000_0001, "R2");
        acc(1'b0, 32'h4200_2024, 2'd2, 32'h0, "R2");
        acc(1'b0, 32'h4000_0100, 2'd2, 32'h0, "R2");
        acc(1'b0, 32'h4200_0000, 2'd2, 32'h0, "R2");
        acc(1'b0, 32'h43FF_FFFC, 2'd2, 32'h0, "R2");
        // Last alias word of the data window
        acc(1'b1, 32'h23FF_FFFC, 2'd2, 32'h7FFF_FFFF, "R1");
        acc(1'b0, 32'h23FF_FFFC, 2'd2, 32'h0, "R1");
        // Back-to-back alias writes
        acc(1'b1, 32'h2200_0280, 2'd2, 32'h0000_0001, "R5");
        acc(1'b1, 32'h2200_0284, 2'd2, 32'h0000_0000, "R5");
        acc(1'b0, 32'h2000_0014, 2'd2, 32'h0, "R4");
        // Just outside the windows, and a sub-word pass-through
        acc(1'b0, 32'h21FF_FFFC, 2'd2, 32'h0, "R9");
        acc(1'b0, 32'h2400_0000, 2'd2, 32'h0, "R9");
        acc(1'b1, 32'h4400_0000, 2'd2, 32'h1234_5678, "R9");
        acc(1'b0, 32'h2000_0003, 2'd0, 32'h0, "R6");
        acc(1'b1, 32'h2000_0022, 2'd1, 32'hCAFE_0001, "R6");
        idle(4);

        chk("R4", 32'(mq.size()), 32'd0, "missing memory transfers");
        chk("R3", 32'(rq.size()), 32'd0, "missing read responses");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule